// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This block is the digital sequencer that paces the analog front end of a successive-approximation converter across a scan of up to eight input channels. A scan begins when the start flag is set. Four sources can set it: a software register write, either of two timer trigger lines, or an external trigger pin. The flag is set only when the sequencer is idle and at least one channel is selected. The sequencer then raises one phase strobe at a time, in this order: a start delay, offset cancellation, and a dedicated hold phase. The dedicated hold phase serves the channel group 0 to 2, which has its own per-channel sample-and-hold circuits. After that, for each selected channel in ascending order, it runs a common sample phase followed by a conversion phase. The conversion phase lasts a programmable number of bit cycles, which stands in for the bit-by-bit logic.

Every phase length is a clock count, and it is captured together with the channel mask and the scan mode when a start is accepted. In single mode the start flag clears itself when the scan ends. In continuous mode the scan repeats. Each repeat drops the start delay and spends a fixed six-clock restart gap in its place. Software stops a continuous run by clearing the start flag. The sequence then halts at the end of the conversion that is running or that begins next. All pins are plain control and status signals; none of them carries a data stream.

Top module: `adc_phase_seq`

## Requirements
- R1: After reset, busy, start_flag, done, all phase strobes and grp_hold are 0.
- R2: When idle with a non-zero chan_mask, a one-cycle high on any of sw_start_set, tmr_a_trig, tmr_b_trig or ext_trig makes busy and start_flag high from the next cycle, and ph_delay is the first strobe.
- R3: While busy, exactly one strobe among ph_delay, ph_gap, ph_ofc, ph_hold, ph_samp and ph_conv is high. The order per scan is delay (or gap), ofc, hold, then a samp/conv pair for each selected channel.
- R4: Each phase lasts its programmed count in clocks (len_delay, len_ofc, len_hold, len_samp, len_bits). A count of 0 acts as 1.
- R5: The hold phase lasts len_hold clocks whether one, two, three or none of channels 0 to 2 are selected. During it, grp_hold[i] is high exactly for the selected channels i in 0 to 2.
- R6: Selected channels are visited in ascending index order, and chan_o holds the channel index during its samp and conv phases.
- R7: done is high for exactly one cycle, which is the last cycle of the final conversion of a scan. A single scan with N channels therefore ends with done in cycle T = tD + tOFC + tHOLD + N*(tSAMP + tBITS) after the start.
- R8: In single mode, busy and start_flag are both 0 in the cycle after done.
- R9: In continuous mode each scan after the first replaces the delay phase with a 6-clock ph_gap phase, so it takes T - tD + 6 clocks.
- R10: Start events that arrive while busy, including in the done cycle, are ignored and do not cause a further scan.
- R11: A high on sw_start_clr clears start_flag from the next cycle. The sequencer then goes idle at the end of the conversion that is running or that begins next. If that clear arrives in the done cycle of a continuous scan, the sequencer goes idle with no further scan.
- R12: The lengths, chan_mask and cont_mode are captured at the start; changing them during a scan has no effect on it.
- R13: A start event while chan_mask is 0 is ignored: busy and start_flag stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start_set | input | 1 | Register write setting the start flag |
| sw_start_clr | input | 1 | Register write clearing the start flag |
| tmr_a_trig | input | 1 | Start request from timer unit A |
| tmr_b_trig | input | 1 | Start request from timer unit B |
| ext_trig | input | 1 | External start trigger |
| cont_mode | input | 1 | 1 = continuous scan, 0 = single scan |
| chan_mask | input | CH_N | Channel selection, bit i = channel i |
| len_delay | input | LEN_W | Start delay length in clocks |
| len_ofc | input | LEN_W | Offset cancel length in clocks |
| len_hold | input | LEN_W | Dedicated hold length in clocks |
| len_samp | input | LEN_W | Common sample length in clocks |
| len_bits | input | LEN_W | Conversion bit-cycle count |
| start_flag | output | 1 | Start flag state |
| busy | output | 1 | Sequence in progress |
| ph_delay | output | 1 | Start delay phase |
| ph_gap | output | 1 | Continuous restart gap phase |
| ph_ofc | output | 1 | Offset cancel phase |
| ph_hold | output | 1 | Dedicated group hold phase |
| ph_samp | output | 1 | Common sample phase |
| ph_conv | output | 1 | Conversion phase |
| grp_hold | output | GRP_N | Per-channel hold enables for channels 0 to 2 |
| chan_o | output | CH_W | Channel being sampled or converted |
| done | output | 1 | End-of-scan pulse |

## Verification
Two events can land in the same cycle: the end of a scan, which raises done, and a stop or start request. The bench drives sw_start_clr together with tmr_a_trig in exactly the done cycle of a continuous scan. It judges the result by requiring that done is seen once, that busy and start_flag are low on the next cycle, and that no phase strobe or done appears for twenty more cycles. A second case clears the flag during the restart gap and measures that busy falls right after the first conversion of the new scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DELAY,
    PH_GAP,
    PH_OFC,
    PH_HOLD,
    PH_SAMP,
    PH_CONV
  } phase_e;
endpackage

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic trig_a,
  input  logic trig_b,
  input  logic trig_ext,
  input  logic idle,
  input  logic mask_any,
  input  logic seq_end,
  output logic accept,
  output logic stop_req,
  output logic flag
);
  logic any_evt;

  assign any_evt  = sw_set | trig_a | trig_b | trig_ext;
  // starts only count from idle with something to convert
  assign accept   = idle & mask_any & any_evt;
  // stop seen the same cycle the clear write lands
  assign stop_req = ~flag | sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (accept)           flag <= 1'b1;
    else if (sw_clr | seq_end) flag <= 1'b0;
  end
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int CH_N = 8,
  parameter int CH_W = 3
) (
  input  logic [CH_N-1:0] mask,
  input  logic [CH_W:0]   floor_i,
  output logic            found,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    // descending walk, so the lowest qualifying index is written last
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (mask[i] && ((CH_W+1)'(i) >= floor_i)) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_N     = 8,
  parameter int GRP_N    = 3,
  parameter int LEN_W    = 8,
  parameter int CONT_GAP = 6,
  localparam int CH_W    = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start_set,
  input  logic             sw_start_clr,
  input  logic             tmr_a_trig,
  input  logic             tmr_b_trig,
  input  logic             ext_trig,
  input  logic             cont_mode,
  input  logic [CH_N-1:0]  chan_mask,
  input  logic [LEN_W-1:0] len_delay,
  input  logic [LEN_W-1:0] len_ofc,
  input  logic [LEN_W-1:0] len_hold,
  input  logic [LEN_W-1:0] len_samp,
  input  logic [LEN_W-1:0] len_bits,
  output logic             start_flag,
  output logic             busy,
  output logic             ph_delay,
  output logic             ph_gap,
  output logic             ph_ofc,
  output logic             ph_hold,
  output logic             ph_samp,
  output logic             ph_conv,
  output logic [GRP_N-1:0] grp_hold,
  output logic [CH_W-1:0]  chan_o,
  output logic             done
);
  phase_e           state, state_nxt;
  logic [CH_N-1:0]  mask_r;
  logic             cont_r;
  logic [LEN_W-1:0] ofc_r, hold_r, samp_r, bits_r;
  logic [CH_W-1:0]  chan_r, chan_nxt;
  logic             accept, stop_req, seq_end;
  logic             tm_load, tm_exp;
  logic [LEN_W-1:0] tm_len;
  logic             pk_found;
  logic [CH_W-1:0]  pk_idx;
  logic [CH_W:0]    pk_floor;
  logic             done_c;

  adc_start_ctrl u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_set   (sw_start_set),
    .sw_clr   (sw_start_clr),
    .trig_a   (tmr_a_trig),
    .trig_b   (tmr_b_trig),
    .trig_ext (ext_trig),
    .idle     (state == PH_IDLE),
    .mask_any (|chan_mask),
    .seq_end  (seq_end),
    .accept   (accept),
    .stop_req (stop_req),
    .flag     (start_flag)
  );

  adc_phase_timer #(.W(LEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tm_load),
    .len     (tm_len),
    .expired (tm_exp)
  );

  // first pick after hold starts from 0, later picks from the next index up
  assign pk_floor = (state == PH_HOLD) ? '0 : ({1'b0, chan_r} + 1'b1);

  adc_chan_pick #(.CH_N(CH_N), .CH_W(CH_W)) u_pick (
    .mask    (mask_r),
    .floor_i (pk_floor),
    .found   (pk_found),
    .idx     (pk_idx)
  );

  always_comb begin
    state_nxt = state;
    chan_nxt  = chan_r;
    tm_load   = 1'b0;
    tm_len    = '0;
    seq_end   = 1'b0;
    done_c    = 1'b0;
    unique case (state)
      PH_IDLE: if (accept) begin
        state_nxt = PH_DELAY;
        tm_load   = 1'b1;
        tm_len    = len_delay;
      end
      PH_DELAY, PH_GAP: if (tm_exp) begin
        state_nxt = PH_OFC;
        tm_load   = 1'b1;
        tm_len    = ofc_r;
      end
      PH_OFC: if (tm_exp) begin
        state_nxt = PH_HOLD;
        tm_load   = 1'b1;
        tm_len    = hold_r;
      end
      PH_HOLD: if (tm_exp) begin
        state_nxt = PH_SAMP;
        chan_nxt  = pk_idx;
        tm_load   = 1'b1;
        tm_len    = samp_r;
      end
      PH_SAMP: if (tm_exp) begin
        state_nxt = PH_CONV;
        tm_load   = 1'b1;
        tm_len    = bits_r;
      end
      PH_CONV: if (tm_exp) begin
        if (!pk_found) begin
          done_c = 1'b1;
          if (cont_r && !stop_req) begin
            state_nxt = PH_GAP;
            tm_load   = 1'b1;
            tm_len    = LEN_W'(CONT_GAP);
          end else begin
            state_nxt = PH_IDLE;
            seq_end   = 1'b1;
          end
        end else if (stop_req) begin
          state_nxt = PH_IDLE;
          seq_end   = 1'b1;
        end else begin
          state_nxt = PH_SAMP;
          chan_nxt  = pk_idx;
          tm_load   = 1'b1;
          tm_len    = samp_r;
        end
      end
      default: state_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      chan_r <= '0;
      mask_r <= '0;
      cont_r <= 1'b0;
      ofc_r  <= '0;
      hold_r <= '0;
      samp_r <= '0;
      bits_r <= '0;
    end else begin
      state  <= state_nxt;
      chan_r <= chan_nxt;
      if (accept) begin
        mask_r <= chan_mask;
        cont_r <= cont_mode;
        ofc_r  <= len_ofc;
        hold_r <= len_hold;
        samp_r <= len_samp;
        bits_r <= len_bits;
      end
    end
  end

  assign busy     = (state != PH_IDLE);
  assign ph_delay = (state == PH_DELAY);
  assign ph_gap   = (state == PH_GAP);
  assign ph_ofc   = (state == PH_OFC);
  assign ph_hold  = (state == PH_HOLD);
  assign ph_samp  = (state == PH_SAMP);
  assign ph_conv  = (state == PH_CONV);
  assign chan_o   = chan_r;
  assign done     = done_c;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp_hold[g] = ph_hold & mask_r[g];
  end
endmodule

// File: rtl/adc_phase_seq_chk.sv
module adc_phase_seq_chk #(
  parameter int CH_N  = 8,
  parameter int GRP_N = 3,
  localparam int CH_W = $clog2(CH_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_start_set,
  input logic [CH_N-1:0]  chan_mask,
  input logic             start_flag,
  input logic             busy,
  input logic             ph_delay,
  input logic             ph_gap,
  input logic             ph_ofc,
  input logic             ph_hold,
  input logic             ph_samp,
  input logic             ph_conv,
  input logic [GRP_N-1:0] grp_hold,
  input logic [CH_W-1:0]  chan_o,
  input logic             done
);
  logic [5:0] strobes;
  assign strobes = {ph_delay, ph_gap, ph_ofc, ph_hold, ph_samp, ph_conv};

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (strobes == '0) && !done && (grp_hold == '0));

  a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(strobes) == 1);

  a_r3_ofc_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_ofc) |-> ($past(ph_delay) || $past(ph_gap)));

  a_r3_hold_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_hold) |-> $past(ph_ofc));

  a_r3_conv_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_conv) |-> $past(ph_samp));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ph_samp) && $past(ph_conv)) |-> (chan_o > $past(chan_o)));

  a_r7_done_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ph_conv);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sw_start_set && (chan_mask != '0)) |=> (busy && start_flag && ph_delay));

  a_r13_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (chan_mask == '0)) |=> !busy);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !start_flag);

  a_r5_grp_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hold != '0) |-> ph_hold);

  a_r9_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_gap) |-> $past(done));
endmodule

bind adc_phase_seq adc_phase_seq_chk #(.CH_N(CH_N), .GRP_N(GRP_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_start_set (sw_start_set),
  .chan_mask    (chan_mask),
  .start_flag   (start_flag),
  .busy         (busy),
  .ph_delay     (ph_delay),
  .ph_gap       (ph_gap),
  .ph_ofc       (ph_ofc),
  .ph_hold      (ph_hold),
  .ph_samp      (ph_samp),
  .ph_conv      (ph_conv),
  .grp_hold     (grp_hold),
  .chan_o       (chan_o),
  .done         (done)
);

// File: tb/adc_phase_seq_tb.sv
module adc_phase_seq_tb;
  localparam int CH_N = 8, GRP_N = 3, LEN_W = 8, CH_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start_set = 0, sw_start_clr = 0, tmr_a_trig = 0, tmr_b_trig = 0, ext_trig = 0;
  logic cont_mode = 0;
  logic [CH_N-1:0] chan_mask = '0;
  logic [LEN_W-1:0] len_delay = '0, len_ofc = '0, len_hold = '0, len_samp = '0, len_bits = '0;
  logic start_flag, busy, ph_delay, ph_gap, ph_ofc, ph_hold, ph_samp, ph_conv, done;
  logic [GRP_N-1:0] grp_hold;
  logic [CH_W-1:0] chan_o;

  always #4 clk = ~clk;

  adc_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
    .tmr_a_trig(tmr_a_trig), .tmr_b_trig(tmr_b_trig), .ext_trig(ext_trig),
    .cont_mode(cont_mode), .chan_mask(chan_mask), .len_delay(len_delay), .len_ofc(len_ofc),
    .len_hold(len_hold), .len_samp(len_samp), .len_bits(len_bits), .start_flag(start_flag),
    .busy(busy), .ph_delay(ph_delay), .ph_gap(ph_gap), .ph_ofc(ph_ofc), .ph_hold(ph_hold),
    .ph_samp(ph_samp), .ph_conv(ph_conv), .grp_hold(grp_hold), .chan_o(chan_o), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // results of the last observe call
  int done_n, c_delay, c_gap, c_ofc, c_hold, c_samp, c_conv, n_ch;
  int ch_seq[8];
  logic [GRP_N-1:0] grp_seen;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int d, int o, int h, int s, int b, int m, bit c);
    len_delay = LEN_W'(d); len_ofc = LEN_W'(o); len_hold = LEN_W'(h);
    len_samp = LEN_W'(s); len_bits = LEN_W'(b); chan_mask = CH_N'(m); cont_mode = c;
  endtask

  // src: 0 software, 1 timer A, 2 timer B, 3 external; returns at cycle n=1
  task automatic kick(int src);
    @(negedge clk);
    case (src)
      0: sw_start_set = 1; 1: tmr_a_trig = 1; 2: tmr_b_trig = 1; default: ext_trig = 1;
    endcase
    @(negedge clk);
    sw_start_set = 0; tmr_a_trig = 0; tmr_b_trig = 0; ext_trig = 0;
  endtask

  // counts cycles from the current negedge (n=1) up to and including done
  task automatic observe();
    bit prev_samp = 0;
    done_n = -1; c_delay = 0; c_gap = 0; c_ofc = 0; c_hold = 0; c_samp = 0; c_conv = 0;
    n_ch = 0; grp_seen = '0;
    for (int n = 1; n <= 2000; n++) begin
      c_delay += int'(ph_delay); c_gap += int'(ph_gap); c_ofc += int'(ph_ofc);
      c_hold += int'(ph_hold); c_samp += int'(ph_samp); c_conv += int'(ph_conv);
      grp_seen |= grp_hold;
      if (ph_samp && !prev_samp && n_ch < 8) begin ch_seq[n_ch] = int'(chan_o); n_ch++; end
      prev_samp = ph_samp;
      if (done) begin done_n = n; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "start_flag", int'(start_flag), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "strobes", int'({ph_delay, ph_gap, ph_ofc, ph_hold, ph_samp, ph_conv, grp_hold}), 0);
  endtask

  task automatic t_single_sw();
    set_cfg(3, 2, 4, 2, 5, 'h05, 0);
    kick(0);
    chk("R2", "busy after sw start", int'(busy), 1);
    chk("R2", "start_flag after sw start", int'(start_flag), 1);
    chk("R2", "first phase is delay", int'(ph_delay), 1);
    observe();
    chk("R7", "single scan length", done_n, 23);
    chk("R4", "delay clocks", c_delay, 3);
    chk("R4", "ofc clocks", c_ofc, 2);
    chk("R4", "hold clocks", c_hold, 4);
    chk("R4", "samp clocks", c_samp, 4);
    chk("R4", "conv clocks", c_conv, 10);
    chk("R6", "channel count", n_ch, 2);
    chk("R6", "first channel", ch_seq[0], 0);
    chk("R6", "second channel", ch_seq[1], 2);
    chk("R5", "group holds ch0,ch2", int'(grp_seen), 5);
    @(negedge clk);
    chk("R8", "busy after done", int'(busy), 0);
    chk("R8", "start_flag after done", int'(start_flag), 0);
    chk("R7", "done is one cycle", int'(done), 0);
  endtask

  task automatic t_no_group();
    set_cfg(3, 2, 4, 2, 5, 'h80, 0);
    kick(1);
    chk("R2", "busy after timer A", int'(busy), 1);
    observe();
    chk("R5", "hold kept with no group channel", c_hold, 4);
    chk("R5", "no group hold enables", int'(grp_seen), 0);
    chk("R7", "length, channel 7 only", done_n, 16);
    chk("R6", "channel 7 converted", ch_seq[0], 7);
    @(negedge clk);
  endtask

  task automatic t_group_sizes();
    set_cfg(3, 2, 4, 2, 5, 'h07, 0);
    kick(3);
    chk("R2", "busy after ext trigger", int'(busy), 1);
    observe();
    chk("R5", "hold with three group channels", c_hold, 4);
    chk("R5", "three group enables", int'(grp_seen), 7);
    chk("R7", "length, three channels", done_n, 30);
    chk("R6", "third channel", ch_seq[2], 2);
    @(negedge clk);
    set_cfg(3, 2, 4, 2, 5, 'h01, 0);
    kick(2);
    chk("R2", "busy after timer B", int'(busy), 1);
    observe();
    chk("R5", "hold with one group channel", c_hold, 4);
    chk("R5", "one group enable", int'(grp_seen), 1);
    chk("R7", "length, one channel", done_n, 16);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    set_cfg(3, 2, 4, 2, 5, 'h05, 0);
    kick(0);
    fork
      observe();
      begin
        repeat (5) @(negedge clk);
        sw_start_set = 1; ext_trig = 1; tmr_a_trig = 1;
        @(negedge clk);
        sw_start_set = 0; ext_trig = 0; tmr_a_trig = 0;
      end
    join
    chk("R10", "scan length with extra starts", done_n, 23);
    for (int k = 0; k < 30; k++) begin @(negedge clk); extra += int'(busy); end
    chk("R10", "no rescan after ignored starts", extra, 0);
  endtask

  task automatic t_continuous_stop();
    int k = 2;
    int seen_done = 0;
    set_cfg(4, 2, 3, 2, 3, 'h12, 1);
    kick(0);
    observe();
    chk("R7", "first continuous scan", done_n, 19);
    chk("R6", "channels 1 then 4", ch_seq[0] * 10 + ch_seq[1], 14);
    @(negedge clk);
    observe();
    chk("R9", "second continuous scan", done_n, 21);
    chk("R9", "gap clocks", c_gap, 6);
    chk("R9", "no delay in later scan", c_delay, 0);
    @(negedge clk);
    sw_start_clr = 1;
    @(negedge clk);
    sw_start_clr = 0;
    chk("R11", "start_flag cleared", int'(start_flag), 0);
    chk("R11", "still busy after clear", int'(busy), 1);
    while (busy && k < 200) begin seen_done += int'(done); @(negedge clk); k++; end
    chk("R11", "idle after first conversion", k, 17);
    chk("R11", "no done on stop", seen_done, 0);
  endtask

  task automatic t_collide();
    int extra = 0;
    set_cfg(4, 2, 3, 2, 3, 'h12, 1);
    kick(0);
    observe();
    chk("R7", "done before collision", done_n, 19);
    sw_start_clr = 1; tmr_a_trig = 1;
    @(negedge clk);
    sw_start_clr = 0; tmr_a_trig = 0;
    chk("R11", "idle after clear in done cycle", int'(busy), 0);
    chk("R11", "start_flag after collision", int'(start_flag), 0);
    for (int j = 0; j < 20; j++) begin
      extra += int'(busy) + int'(done);
      @(negedge clk);
    end
    chk("R10", "trigger in done cycle ignored", extra, 0);
  endtask

  task automatic t_zero_len();
    set_cfg(0, 0, 0, 0, 0, 'h01, 0);
    kick(0);
    observe();
    chk("R4", "zero lengths act as one", done_n, 5);
    @(negedge clk);
  endtask

  task automatic t_capture();
    set_cfg(3, 2, 4, 2, 5, 'h05, 0);
    kick(0);
    set_cfg(9, 9, 9, 9, 9, 'hFF, 1);
    observe();
    chk("R12", "length uses captured config", done_n, 23);
    chk("R12", "channels use captured mask", n_ch, 2);
    @(negedge clk);
    chk("R12", "mode uses captured single", int'(busy), 0);
  endtask

  task automatic t_empty();
    set_cfg(3, 2, 4, 2, 5, 'h00, 0);
    kick(0);
    chk("R13", "busy with empty mask", int'(busy), 0);
    chk("R13", "start_flag with empty mask", int'(start_flag), 0);
    kick(2);
    chk("R13", "busy with empty mask, timer", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_sw();
    t_no_group();
    t_group_sizes();
    t_busy_ignore();
    t_continuous_stop();
    t_collide();
    t_zero_len();
    t_capture();
    t_empty();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule